// File: doc/BRIEF.md
# Six-Tap Staged-Enable FIR Filter

This block is a direct-form six-tap FIR filter for signed sample streams. A short delay line holds the five previous accepted samples. Each of the six taps has its own multiply-accumulate slice. The slice multiplies its tap sample by that tap's coefficient, keeps the product in a register, and adds the product into a sum chain that runs through the taps. The final sum is registered as the filter output. Coefficients are loaded at run time through a write port that takes a tap index and a value.

A small occupancy state machine produces the enables. The product registers load only when a sample is taken in. The output register loads only when a product set moves forward. No register toggles while the stream is idle or stalled. Samples enter on a valid/ready handshake and results leave on one. Back-pressure works like this: while `out_valid` is high and `out_ready` is low, the output is held. The product stage keeps its contents. `in_ready` falls only when both the product stage and the output stage are occupied and the output is stalled. A sample moves across either interface only on a clock edge where valid and ready are both high.

Top module: `fir6_staged`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. Every delay element reads as zero and every coefficient is zero, so the first outputs after reset count only the taps that have been loaded and sampled since then.
- R2: For accepted samples x[n], `out_data` equals the sum over k = 0..5 of c[k]*x[n-k] as a 31-bit two's-complement value. Samples and coefficients are 13-bit signed, and x[n-k] is the sample accepted k acceptances earlier.
- R3: The delay line shifts only on an accepted sample (`in_valid` and `in_ready` both high). Idle cycles and refused cycles leave the history unchanged.
- R4: With `out_ready` held high, a sample accepted on edge E produces `out_valid` high from edge E+1. `out_valid` is low after E when the pipeline was empty before it.
- R5: A coefficient write (`cw_en` high) to tap index `cw_tap` = k updates c[k] on that edge. A sample accepted on the same edge still uses the old c[k]. Later samples use the new one.
- R6: A coefficient write whose `cw_tap` is 6 or 7 changes no coefficient.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged. `in_ready` is low exactly when both stages are occupied under that stall.
- R8: Each accepted sample yields exactly one output transfer, in acceptance order, with none lost or duplicated.
- R9: A tap's product register changes only on an accepted sample. The output register changes only when a product set moves forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Filter can take a sample |
| in_data | input | 13 | Signed input sample |
| cw_en | input | 1 | Coefficient write strobe |
| cw_tap | input | 3 | Tap index for the write (0..5 valid) |
| cw_val | input | 13 | Signed coefficient value |
| out_valid | output | 1 | Filtered result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 31 | Signed filter output |

## Verification
The filter is first driven with a unit impulse followed by zeros. This shows each coefficient on its own, in tap order, so a swapped tap or an off-by-one delay shows up as a wrong value at a known position. Full-scale negative samples against full-scale negative coefficients reach the largest positive sum, which tests sign extension and the output width. Random samples with idle gaps and random `out_ready` back-pressure show whether the history moves only on accepted samples and whether results are held and kept in order under stalls. Writes made on the same edge as a sample, and writes to tap indices 6 and 7, separate the same-edge coefficient timing from the ignored-index case.

// File: rtl/fir6_pkg.sv
package fir6_pkg;
  // Pipeline occupancy: bit 1 = output stage full, bit 0 = product stage full
  typedef enum logic [1:0] {
    OCC_EMPTY = 2'b00,
    OCC_PROD  = 2'b01,
    OCC_OUT   = 2'b10,
    OCC_BOTH  = 2'b11
  } occ_e;
endpackage

// File: rtl/fir6_ctrl.sv
module fir6_ctrl
  import fir6_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic en_prod,
  output logic en_sum,
  output logic out_valid
);
  occ_e occ_q, occ_d;
  logic prod_full, out_full, drain, prod_next, out_next;

  assign prod_full = (occ_q == OCC_PROD) || (occ_q == OCC_BOTH);
  assign out_full  = (occ_q == OCC_OUT)  || (occ_q == OCC_BOTH);
  assign drain     = !out_full || out_ready;
  assign in_ready  = !prod_full || drain;
  assign en_prod   = in_valid && in_ready;
  assign en_sum    = prod_full && drain;
  assign out_valid = out_full;

  always_comb begin
    prod_next = prod_full;
    if (en_sum)  prod_next = 1'b0;
    if (en_prod) prod_next = 1'b1;
    out_next = out_full;
    if (out_full && out_ready) out_next = 1'b0;
    if (en_sum) out_next = 1'b1;
    occ_d = occ_e'({out_next, prod_next});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) occ_q <= OCC_EMPTY;
    else        occ_q <= occ_d;
  end

  p_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_prod |=> (occ_q == OCC_PROD || occ_q == OCC_BOTH));
  p_emit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_sum |=> out_valid);
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == OCC_BOTH && !out_ready) |=> (occ_q == OCC_BOTH));
endmodule

// File: rtl/fir6_coef_bank.sv
module fir6_coef_bank #(
  parameter int TAPS = 6,
  parameter int CW   = 13,
  localparam int IW  = $clog2(TAPS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [IW-1:0]             idx,
  input  logic [CW-1:0]             val,
  output logic [TAPS-1:0][CW-1:0]   coef
);
  for (genvar k = 0; k < TAPS; k++) begin : g_coef
    always_ff @(posedge clk) begin
      if (!rst_n)                      coef[k] <= '0;
      else if (we && int'(idx) == k)   coef[k] <= val;
    end
  end

  p_bad_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && int'(idx) >= TAPS) |=> $stable(coef));
endmodule

// File: rtl/fir6_delay_line.sv
module fir6_delay_line #(
  parameter int TAPS = 6,
  parameter int DW   = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       shift_en,
  input  logic [DW-1:0]              din,
  output logic [TAPS-2:0][DW-1:0]    hist
);
  for (genvar i = 0; i < TAPS - 1; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)        hist[i] <= '0;
      else if (shift_en) hist[i] <= (i == 0) ? din : hist[(i == 0) ? 0 : i - 1];
    end
  end

  p_hold_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist));
endmodule

// File: rtl/fir6_mac_tap.sv
module fir6_mac_tap #(
  parameter int DW = 13,
  parameter int CW = 13,
  parameter int OW = 31,
  localparam int PW = DW + CW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] x,
  input  logic signed [CW-1:0] c,
  input  logic signed [OW-1:0] sum_in,
  output logic signed [OW-1:0] sum_out
);
  logic signed [PW-1:0] prod_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  prod_q <= '0;
    else if (en) prod_q <= x * c;
  end

  assign sum_out = sum_in + OW'(prod_q);

  p_prod_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(prod_q));
endmodule

// File: rtl/fir6_staged.sv
module fir6_staged
  import fir6_pkg::*;
#(
  parameter int TAPS = 6,
  parameter int DW   = 13,
  parameter int CW   = 13,
  parameter int OW   = 31,
  localparam int IW  = $clog2(TAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DW-1:0]        in_data,
  input  logic                 cw_en,
  input  logic [IW-1:0]        cw_tap,
  input  logic [CW-1:0]        cw_val,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [OW-1:0]        out_data
);
  logic                       en_prod, en_sum;
  logic [TAPS-2:0][DW-1:0]    hist;
  logic [TAPS-1:0][CW-1:0]    coef;
  logic [TAPS-1:0][DW-1:0]    x_tap;
  logic signed [OW-1:0]       sums [TAPS+1];
  logic [OW-1:0]              out_q;

  fir6_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .en_prod(en_prod), .en_sum(en_sum), .out_valid(out_valid)
  );

  fir6_coef_bank #(.TAPS(TAPS), .CW(CW)) u_coef (
    .clk(clk), .rst_n(rst_n), .we(cw_en), .idx(cw_tap), .val(cw_val), .coef(coef)
  );

  fir6_delay_line #(.TAPS(TAPS), .DW(DW)) u_line (
    .clk(clk), .rst_n(rst_n), .shift_en(en_prod), .din(in_data), .hist(hist)
  );

  assign sums[0] = '0;
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    if (k == 0) begin : g_head
      assign x_tap[k] = in_data;
    end else begin : g_body
      assign x_tap[k] = hist[k-1];
    end
    fir6_mac_tap #(.DW(DW), .CW(CW), .OW(OW)) u_mac (
      .clk(clk), .rst_n(rst_n), .en(en_prod),
      .x(x_tap[k]), .c(coef[k]), .sum_in(sums[k]), .sum_out(sums[k+1])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      out_q <= '0;
    else if (en_sum) out_q <= sums[TAPS];
  end
  assign out_data = out_q;

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_out_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_sum |=> $stable(out_q));
endmodule

// File: tb/fir6_staged_bench.sv
module fir6_staged_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [12:0] in_data = '0;
  logic cw_en = 1'b0;
  logic [2:0] cw_tap = '0;
  logic [12:0] cw_val = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [30:0] out_data;

  always #4 clk = ~clk; // 125 MHz

  fir6_staged u_fir6_staged (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cw_en(cw_en), .cw_tap(cw_tap), .cw_val(cw_val),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int errors = 0;
  int checks = 0;
  int bp_mode = 0;          // 0: always ready, 1: random, 2: never ready
  int n_acc = 0;
  int n_out = 0;
  longint m_hist [6];
  longint m_coef [6];
  logic [30:0] exp_q [$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_write(input logic [2:0] idx, input logic [12:0] v);
    if (idx < 3'd6) m_coef[idx] = longint'($signed(v));  // R6: 6 and 7 ignored
  endfunction

  function automatic void model_accept(input logic [12:0] d);
    longint acc;
    for (int k = 5; k > 0; k--) m_hist[k] = m_hist[k-1];
    m_hist[0] = longint'($signed(d));
    acc = 0;
    for (int k = 0; k < 6; k++) acc += m_coef[k] * m_hist[k];
    exp_q.push_back(acc[30:0]);
    n_acc++;
  endfunction

  task automatic send(input logic [12:0] d, input bit we, input logic [2:0] idx,
                      input logic [12:0] v);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; cw_en = we; cw_tap = idx; cw_val = v;
    #1;
    if (in_ready) begin
      model_accept(d);              // R5: same-edge sample uses old coefficient
      if (we) model_write(idx, v);
    end else begin
      if (we) model_write(idx, v);
      @(negedge clk);
      cw_en = 1'b0;
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      model_accept(d);
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0; cw_en = 1'b0;
  endtask

  task automatic write_coef(input logic [2:0] idx, input logic [12:0] v);
    @(negedge clk);
    cw_en = 1'b1; cw_tap = idx; cw_val = v;
    model_write(idx, v);
    @(posedge clk);
    #1;
    cw_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor: drives out_ready, checks hold and compares against the scoreboard
  bit prev_stall = 1'b0;
  logic [30:0] prev_data = '0;
  initial begin
    forever begin
      @(negedge clk);
      out_ready = (bp_mode == 0) ? 1'b1 : (bp_mode == 2) ? 1'b0 : 1'($urandom_range(0, 1));
      #1;
      if (rst_n) begin
        if (prev_stall) begin
          check(out_valid === 1'b1, "R7 valid held", longint'(out_valid), 1);
          check(out_data === prev_data, "R7 data held", longint'(out_data), longint'(prev_data));
        end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R8 unexpected output", longint'($signed(out_data)), 0);
          end else begin
            logic [30:0] e;
            e = exp_q.pop_front();
            check(out_data === e, "R2 output value",
                  longint'($signed(out_data)), longint'($signed(e)));
            n_out++;
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    for (int k = 0; k < 6; k++) begin m_hist[k] = 0; m_coef[k] = 0; end
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R1 reset state
    check(out_valid === 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    check(in_ready === 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);

    // R1/R4: zero coefficients give zero; latency from an empty pipe
    idle(2);
    send(13'd100, 1'b0, 3'd0, '0);
    check(out_valid === 1'b0, "R4 no output one edge early", longint'(out_valid), 0);
    @(posedge clk);
    #1;
    check(out_valid === 1'b1, "R4 output on following edge", longint'(out_valid), 1);
    check(out_data === 31'd0, "R1 zero coefficients", longint'($signed(out_data)), 0);
    idle(3);

    // R2: impulse response shows each tap in order
    write_coef(3'd0, 13'sd3);
    write_coef(3'd1, -13'sd5);
    write_coef(3'd2, 13'sd7);
    write_coef(3'd3, 13'sd11);
    write_coef(3'd4, -13'sd2);
    write_coef(3'd5, 13'sd1);
    send(13'd1, 1'b0, 3'd0, '0);
    for (int i = 0; i < 7; i++) send(13'd0, 1'b0, 3'd0, '0);
    idle(3);

    // R2 boundary: full-scale negatives everywhere
    for (int k = 0; k < 6; k++) write_coef(3'(k), 13'h1000);
    for (int i = 0; i < 6; i++) send(13'h1000, 1'b0, 3'd0, '0);
    send(13'h0FFF, 1'b0, 3'd0, '0);
    idle(3);

    // R5: write on the same edge as a sample
    send(13'd20, 1'b1, 3'd0, 13'sd9);
    send(13'd21, 1'b1, 3'd3, -13'sd4);
    send(13'd22, 1'b0, 3'd0, '0);
    idle(3);

    // R6: out-of-range tap indices change nothing
    write_coef(3'd6, 13'd999);
    write_coef(3'd7, 13'd555);
    send(13'd1, 1'b0, 3'd0, '0);
    send(13'd2, 1'b0, 3'd0, '0);
    idle(3);

    // R7: full stall drops in_ready and holds the output
    bp_mode = 2;
    idle(2);
    send(13'd7, 1'b0, 3'd0, '0);
    send(13'd8, 1'b0, 3'd0, '0);
    check(in_ready === 1'b0, "R7 in_ready low when both stages held",
          longint'(in_ready), 0);
    check(out_valid === 1'b1, "R7 out_valid while stalled", longint'(out_valid), 1);
    idle(5);
    bp_mode = 0;
    idle(4);

    // R3/R8: random samples, idle gaps, random back-pressure, coefficient changes
    bp_mode = 1;
    for (int i = 0; i < 300; i++) begin
      send(13'($urandom), (i % 37) == 5, 3'($urandom_range(0, 7)), 13'($urandom));
      if ((i % 11) == 3) idle(int'($urandom_range(1, 4)));
    end
    bp_mode = 0;
    idle(8);

    // R8: every accepted sample produced exactly one result
    check(exp_q.size() == 0, "R8 pending results", longint'(exp_q.size()), 0);
    check(n_out == n_acc, "R8 result count", longint'(n_out), longint'(n_acc));
    summary();
  end
endmodule